// File: doc/BRIEF.md
# Fully Associative Word Cache

This block is a small cache in which any memory word may sit in any entry. Each entry keeps the complete word address as its tag, a valid flag and one data word. A lookup compares the request address against every stored tag in the same cycle. It reports combinationally whether a valid entry matched, which entry it was, and that entry's word. A separate fill port, driven by whatever fetches words from the backing store, writes an address/word pair into the cache. In the same cycle it reports the entry that the write will land in.

When a fill brings an address that is already present, the existing entry is rewritten, so no address ever occupies two entries. When the address is new, the fill takes the lowest-numbered empty entry. Once every entry is valid, a victim is chosen by a policy fixed at elaboration: pseudo-random, oldest allocation first, or least recently used. The entry count must be a power of two.

Top module: `assoc_word_cache`

## Requirements
- R1: `req_hit` is 1 exactly when `req_valid` is 1 and a valid entry holds a tag equal to `req_addr`. On a hit, `req_idx` names that entry and `req_data` carries its word. On a miss, `req_data` is 0.
- R2: An entry whose valid flag is clear never produces a hit, even when its stored tag equals the request address.
- R3: A fill of an address that is already held rewrites that entry's word, and `fill_idx` reports that entry. No second copy is created.
- R4: A fill of an absent address while some entry is empty goes to the lowest-numbered empty entry.
- R5: With POLICY = REPL_FIFO and all entries valid, a fill of an absent address replaces the entry allocated earliest. Rewrites of present addresses do not change the allocation order.
- R6: With POLICY = REPL_LRU, each entry has an age. A touch (a lookup hit, or any fill) sets the touched entry's age to 0 and adds 1 to every entry whose age was below it. After reset, entry i has age i. With all entries valid, the victim is the entry whose age is N-1.
- R7: With POLICY = REPL_RANDOM, a 16-bit register loads 0xACE1 at reset and shifts left every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10. With all entries valid, the victim is the register's low log2(N) bits in the fill cycle.
- R8: When a lookup and a fill occur in the same cycle, the lookup reports the contents as they were before the fill. For LRU, the lookup's touch is applied first and the fill's touch second. The victim is chosen from the ages held before the cycle.
- R9: After reset, all entries are empty, nothing hits, and the first fill reports entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | AW | Word address to look up |
| req_hit | output | 1 | A valid entry matches the lookup |
| req_idx | output | log2(N) | Matching entry |
| req_data | output | DW | Word of the matching entry, 0 on miss |
| fill_valid | input | 1 | Fill request present |
| fill_addr | input | AW | Word address being filled |
| fill_data | input | DW | Word being filled |
| fill_idx | output | log2(N) | Entry the fill writes this cycle |

## Verification
A lookup and a fill can fall in the same cycle. They may name the same address, a different resident address, or an address that is absent. The bench provokes this on purpose in a directed phase and then heavily in a long random phase over a narrow address range. It judges the result against a behavioural model that answers the lookup from the contents held before the cycle. That model applies the two LRU touches in lookup-then-fill order. Three instances with the three policies run the same stimulus, so any disagreement in the order of these updates shows up in the next victim choice.

// File: rtl/acache_pkg.sv
package acache_pkg;

    typedef enum logic [1:0] {
        REPL_RANDOM = 2'd0,
        REPL_FIFO   = 2'd1,
        REPL_LRU    = 2'd2
    } repl_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // taps 16,14,13,11 of a maximal-length Fibonacci register
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/acache_store.sv
module acache_store #(
    parameter int N  = 8,
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] probe_addr,
    output logic [N-1:0]  valid_vec,
    output logic [N-1:0]  lk_match,
    output logic [N-1:0]  probe_match,
    output logic [DW-1:0] lk_word
);

    typedef struct packed {
        logic [N-1:0]         valid;
        logic [N-1:0][AW-1:0] tag;
        logic [N-1:0][DW-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = wr_addr;
            st_d.data[wr_idx]  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // parallel compare of every entry; an empty entry never matches
    always_comb begin
        lk_word = '0;
        for (int i = 0; i < N; i++) begin
            lk_match[i]    = st_q.valid[i] && (st_q.tag[i] == lk_addr);
            probe_match[i] = st_q.valid[i] && (st_q.tag[i] == probe_addr);
            if (lk_match[i]) lk_word = lk_word | st_q.data[i];
        end
    end

    assign valid_vec = st_q.valid;

    // R3
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R9
    empty_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid_vec == '0));

endmodule

// File: rtl/acache_victim.sv
module acache_victim #(
    parameter int N = 8,
    parameter acache_pkg::repl_e POLICY = acache_pkg::REPL_LRU,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic [IW-1:0] a_idx,
    input  logic          b_en,
    input  logic [IW-1:0] b_idx,
    input  logic          alloc,
    output logic [IW-1:0] victim
);
    import acache_pkg::*;

    typedef logic [N-1:0][IW-1:0] age_vec_t;

    function automatic age_vec_t touch(input age_vec_t a, input logic [IW-1:0] k);
        age_vec_t r;
        logic [IW-1:0] ref_age;
        r       = a;
        ref_age = a[k];
        for (int j = 0; j < N; j++)
            if (a[j] < ref_age) r[j] = a[j] + 1'b1;
        r[k] = '0;
        return r;
    endfunction

    generate
        if (POLICY == REPL_LRU) begin : g_lru
            typedef struct packed { age_vec_t age; } lru_st_t;
            lru_st_t st_d, st_q;
            logic [N-1:0] oldest;
            logic unused_alloc;

            assign unused_alloc = alloc;

            always_comb begin
                st_d = st_q;
                if (a_en) st_d.age = touch(st_d.age, a_idx);
                if (b_en) st_d.age = touch(st_d.age, b_idx);
                victim = '0;
                for (int i = 0; i < N; i++) begin
                    oldest[i] = (st_q.age[i] == IW'(N - 1));
                    if (oldest[i]) victim = IW'(i);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) st_q.age[i] <= IW'(i);
                end else begin
                    st_q <= st_d;
                end
            end

            // R6
            one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(oldest) == 1);
        end else if (POLICY == REPL_FIFO) begin : g_fifo
            typedef struct packed { logic [IW-1:0] ptr; } fifo_st_t;
            fifo_st_t st_d, st_q;
            logic unused_touch;

            assign unused_touch = ^{a_en, a_idx, b_en, b_idx};

            always_comb begin
                st_d = st_q;
                if (alloc) st_d.ptr = st_q.ptr + 1'b1;
                victim = st_q.ptr;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            // R5
            order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !alloc |=> $stable(st_q.ptr));
        end else begin : g_rand
            typedef struct packed { logic [LFSR_W-1:0] lfsr; } rand_st_t;
            rand_st_t st_d, st_q;
            logic unused_inputs;

            assign unused_inputs = ^{a_en, a_idx, b_en, b_idx, alloc};

            always_comb begin
                st_d.lfsr = lfsr_next(st_q.lfsr);
                victim    = st_q.lfsr[IW-1:0];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q.lfsr <= LFSR_SEED;
                else        st_q <= st_d;
            end

            // R7
            lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.lfsr != '0);
        end
    endgenerate

endmodule

// File: rtl/assoc_word_cache.sv
module assoc_word_cache #(
    parameter int N  = 8,
    parameter int AW = 8,
    parameter int DW = 32,
    parameter acache_pkg::repl_e POLICY = acache_pkg::REPL_LRU,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_hit,
    output logic [IW-1:0] req_idx,
    output logic [DW-1:0] req_data,
    input  logic          fill_valid,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    output logic [IW-1:0] fill_idx
);

    logic [N-1:0]  valid_vec, lk_match, fl_match;
    logic [DW-1:0] lk_word;
    logic [IW-1:0] victim, first_empty, fl_hit_idx;
    logic          fl_present, all_valid;

    acache_store #(.N(N), .AW(AW), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_addr     (req_addr),
        .wr_en       (fill_valid),
        .wr_idx      (fill_idx),
        .wr_addr     (fill_addr),
        .wr_data     (fill_data),
        .probe_addr  (fill_addr),
        .valid_vec   (valid_vec),
        .lk_match    (lk_match),
        .probe_match (fl_match),
        .lk_word     (lk_word)
    );

    always_comb begin
        req_idx     = '0;
        fl_hit_idx  = '0;
        first_empty = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) req_idx    = req_idx | IW'(i);
            if (fl_match[i]) fl_hit_idx = fl_hit_idx | IW'(i);
        end
        for (int i = N - 1; i >= 0; i--)
            if (!valid_vec[i]) first_empty = IW'(i);
        fl_present = |fl_match;
        all_valid  = &valid_vec;
        req_hit    = req_valid && (|lk_match);
        req_data   = req_hit ? lk_word : '0;
        if (fl_present)     fill_idx = fl_hit_idx;
        else if (all_valid) fill_idx = victim;
        else                fill_idx = first_empty;
    end

    acache_victim #(.N(N), .POLICY(POLICY)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (req_hit),
        .a_idx  (req_idx),
        .b_en   (fill_valid),
        .b_idx  (fill_idx),
        .alloc  (fill_valid && !fl_present),
        .victim (victim)
    );

    // R1
    hit_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> valid_vec[req_idx]);

    // R3
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> valid_vec[$past(fill_idx)]);

    // R4
    fill_empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fl_present && !all_valid) |-> !valid_vec[fill_idx]);

endmodule

// File: tb/assoc_word_cache_tb.sv
module assoc_word_cache_tb;
    import acache_pkg::*;

    localparam int N  = 8;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;

    // index 0: LRU, 1: FIFO, 2: random
    logic          hit_w  [3];
    logic [IW-1:0] idx_w  [3];
    logic [DW-1:0] data_w [3];
    logic [IW-1:0] fidx_w [3];

    assoc_word_cache #(.N(N), .AW(AW), .DW(DW), .POLICY(REPL_LRU)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_hit(hit_w[0]), .req_idx(idx_w[0]), .req_data(data_w[0]),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_idx(fidx_w[0]));

    assoc_word_cache #(.N(N), .AW(AW), .DW(DW), .POLICY(REPL_FIFO)) u_dut_fifo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_hit(hit_w[1]), .req_idx(idx_w[1]), .req_data(data_w[1]),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_idx(fidx_w[1]));

    assoc_word_cache #(.N(N), .AW(AW), .DW(DW), .POLICY(REPL_RANDOM)) u_dut_rnd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_hit(hit_w[2]), .req_idx(idx_w[2]), .req_data(data_w[2]),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_idx(fidx_w[2]));

    // behavioural reference state
    bit            mv [3][N];
    logic [AW-1:0] mt [3][N];
    logic [DW-1:0] md [3][N];
    int            age [N];
    int            ptr;
    logic [15:0]   lf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lru_touch(input int k);
        int r;
        r = age[k];
        for (int j = 0; j < N; j++)
            if (age[j] < r) age[j]++;
        age[k] = 0;
    endtask

    // one cycle: drive, compare against model, advance model, wait for next negedge
    task automatic step(input bit lv, input logic [AW-1:0] la,
                        input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd);
        req_valid  = lv;
        req_addr   = la;
        fill_valid = fv;
        fill_addr  = fa;
        fill_data  = fd;
        #1;
        for (int p = 0; p < 3; p++) begin
            int li, fi, fe, tgt;
            bit eh;
            string tg;
            li = -1; fi = -1; fe = -1; tgt = 0;
            for (int i = 0; i < N; i++) begin
                if (mv[p][i] && mt[p][i] == la) li = i;
                if (mv[p][i] && mt[p][i] == fa) fi = i;
                if (!mv[p][i] && fe < 0) fe = i;
            end
            eh = lv && (li >= 0);
            tg = (lv && fv) ? "R8 lookup beside fill" : "R1 lookup";
            check($sformatf("%s hit p%0d", tg, p), 32'(hit_w[p]), 32'(eh));
            if (eh) begin
                check($sformatf("%s idx p%0d", tg, p), 32'(idx_w[p]), 32'(li));
                check($sformatf("%s data p%0d", tg, p), data_w[p], md[p][li]);
            end else begin
                check($sformatf("R1 miss data p%0d", p), data_w[p], 32'd0);
            end
            if (fv) begin
                if (fi >= 0) begin
                    tgt = fi;
                    check("R3 rewrite existing entry", 32'(fidx_w[p]), 32'(tgt));
                end else if (fe >= 0) begin
                    tgt = fe;
                    check("R4 lowest empty entry", 32'(fidx_w[p]), 32'(tgt));
                end else if (p == 0) begin
                    for (int i = 0; i < N; i++) if (age[i] == N - 1) tgt = i;
                    check("R6 LRU victim", 32'(fidx_w[p]), 32'(tgt));
                end else if (p == 1) begin
                    tgt = ptr;
                    check("R5 FIFO victim", 32'(fidx_w[p]), 32'(tgt));
                end else begin
                    tgt = int'(lf[IW-1:0]);
                    check("R7 random victim", 32'(fidx_w[p]), 32'(tgt));
                end
            end
            if (p == 0) begin
                if (eh) lru_touch(li);
                if (fv) lru_touch(tgt);
            end
            if (fv) begin
                if (p == 1 && fi < 0) ptr = (ptr + 1) % N;
                mv[p][tgt] = 1'b1;
                mt[p][tgt] = fa;
                md[p][tgt] = fd;
            end
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        @(negedge clk);
    endtask

    initial begin
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < N; i++) begin
                mv[p][i] = 1'b0; mt[p][i] = '0; md[p][i] = '0;
            end
        for (int i = 0; i < N; i++) age[i] = i;
        ptr = 0;
        lf  = 16'hACE1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: empty after reset, first fill to entry 0
        req_valid = 1'b1; req_addr = 8'h00; fill_valid = 1'b1; fill_addr = 8'h03;
        #1;
        for (int p = 0; p < 3; p++) begin
            check("R9 no hit after reset", 32'(hit_w[p]), 32'd0);
            check("R9 first fill entry", 32'(fidx_w[p]), 32'd0);
        end
        step(1'b1, 8'h00, 1'b1, 8'h03, 32'hD000_0003);

        // fill the remaining entries while hitting on the first
        for (int i = 0; i < 7; i++)
            step(1'b1, 8'h03, 1'b1, AW'(8'h10 + i), 32'hA000_0000 + i);

        // R3: rewrite of a present address
        step(1'b0, 8'h00, 1'b1, 8'h12, 32'h1234_5678);
        step(1'b1, 8'h12, 1'b0, 8'h00, 32'h0);

        // R2: address never filled misses; disabled lookup of present address misses
        step(1'b1, 8'h00, 1'b0, 8'h00, 32'h0);
        step(1'b0, 8'h12, 1'b0, 8'h00, 32'h0);

        // touch a few entries, then evict repeatedly
        step(1'b1, 8'h10, 1'b0, 8'h00, 32'h0);
        step(1'b1, 8'h14, 1'b0, 8'h00, 32'h0);
        for (int k = 0; k < 10; k++)
            step(1'b1, 8'h11, 1'b1, AW'(8'h40 + k), 32'hB000_0000 + k);

        // R8: same-cycle lookup and fill of the same address, present and absent
        step(1'b1, 8'h11, 1'b1, 8'h11, 32'hCAFE_0011);
        step(1'b1, 8'h11, 1'b0, 8'h00, 32'h0);
        step(1'b1, 8'h77, 1'b1, 8'h77, 32'hCAFE_0077);
        step(1'b1, 8'h77, 1'b0, 8'h00, 32'h0);

        // mixed random traffic over a narrow address range
        for (int k = 0; k < 600; k++)
            step(1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, 19)),
                 1'($urandom_range(0, 1)), AW'($urandom_range(0, 19)), $urandom);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule